// File: doc/BRIEF.md
# Four-Entry Host Byte Buffer for an I2C Master

This block is the byte staging store between a host register port and the transfer engine of an I2C master. The host pushes bytes one at a time through a write strobe and pops them through a read strobe. The popped byte is always the oldest one, and the remaining bytes move one place toward the head. After a receive, the transfer engine can load the whole store in one cycle, together with the number of bytes that arrived. A flush input empties the store.

Two status outputs go to the host status register: "has data" and "full". They are not decoded from the fill level. Each one is set or cleared only on particular fill-level steps, and an engine load can set them but never clears them. Software sees exactly that sticky behaviour. A read from an empty store returns all-ones and has no other effect.

Top module: `host_byte_buffer`

## Requirements
- R1: After reset the store is empty, `has_data` and `is_full` are 0, and `rd_data` reads 0xFF.
- R2: A host write while four bytes are held is dropped: contents, level and both flags are unchanged.
- R3: Otherwise a host write places the byte behind the last held byte. A write into an empty store sets `has_data`, and a write that brings the count to four sets `is_full`.
- R4: When the store is empty, `rd_data` is 0xFF and a read strobe changes nothing.
- R5: When bytes are held, `rd_data` shows the oldest byte. A read strobe removes it, moves the others one place toward the head, and lowers the count by one.
- R6: A read taken with four bytes held clears `is_full`. A read taken with one byte held clears `has_data`. No other read changes either flag.
- R7: `flush` empties the store, zeroes every entry and clears both flags. It takes priority over a load and over host strobes in the same cycle.
- R8: `ld_en` replaces entries 0..n-1 with the bytes of `ld_data`, entry i taken from bits [8i+7:8i], and sets the level to n = `ld_count`. A value above 4 counts as 4. The load sets `has_data` if n is at least 1 and sets `is_full` if n is 4. It never clears a flag, and host strobes in the same cycle are ignored.
- R9: A read and a write in the same cycle act as the read followed by the write. With four bytes held, both take effect, and the level and `is_full` stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe (pops on the clock edge) |
| rd_data | output | 8 | Head byte, or 0xFF when empty |
| ld_en | input | 1 | Engine parallel load strobe |
| ld_data | input | 32 | Engine bytes, entry i in bits [8i+7:8i] |
| ld_count | input | 3 | Number of bytes loaded (above 4 counts as 4) |
| flush | input | 1 | Empty and zero the store |
| has_data | output | 1 | Sticky "some data" flag |
| is_full | output | 1 | Sticky "full" flag |

## Verification
A host read and a host write can arrive in the same cycle. Their order decides the outcome at the two boundaries: at four bytes held, the write lands and `is_full` is cleared and then set again; at one byte held, `has_data` is cleared and then set again. The bench drives both strobes together at those levels in directed steps, and many more times through random stimulus. Each time it compares the head byte, the order of the following reads and both flags against a model that applies the pop before the push.

// File: rtl/hbb_pkg.sv
`timescale 1ns/1ps
package hbb_pkg;

  typedef struct packed {
    logic flush;
    logic load;
    logic pop;
    logic push;
  } hbb_ev_t;

  function automatic int clamp_count(int req, int depth);
    return (req > depth) ? depth : req;
  endfunction

  function automatic logic can_pop(int lvl);
    return lvl != 0;
  endfunction

  function automatic logic can_push(int lvl, int depth);
    return lvl < depth;
  endfunction

endpackage

// File: rtl/hbb_ctrl.sv
`timescale 1ns/1ps
module hbb_ctrl
  import hbb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic          flush,
  input  logic          ld_en,
  input  logic [LW-1:0] ld_count,
  input  logic [LW-1:0] level,
  output hbb_ev_t       ev,
  output logic [LW-1:0] lvl_mid,
  output logic [LW-1:0] load_n
);
  logic host_ok;

  always_comb begin
    host_ok  = ~flush & ~ld_en;
    ev.flush = flush;
    ev.load  = ld_en & ~flush;
    ev.pop   = host_ok & rd_en & can_pop(int'(level));
    lvl_mid  = level - LW'(ev.pop);
    ev.push  = host_ok & wr_en & can_push(int'(lvl_mid), DEPTH);
    load_n   = LW'(clamp_count(int'(ld_count), DEPTH));
  end

endmodule

// File: rtl/hbb_level.sv
`timescale 1ns/1ps
module hbb_level
  import hbb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hbb_ev_t       ev,
  input  logic [LW-1:0] lvl_mid,
  input  logic [LW-1:0] load_n,
  output logic [LW-1:0] level
);
  logic [LW-1:0] level_nx;

  always_comb begin
    if (ev.flush)     level_nx = '0;
    else if (ev.load) level_nx = load_n;
    else              level_nx = lvl_mid + LW'(ev.push);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else        level <= level_nx;
  end

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R1

  AST_POP_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.pop && !ev.push) |=> (level == $past(level) - LW'(1))); // R5

  AST_LOAD_SETS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ev.load |=> (level == $past(load_n))); // R8

endmodule

// File: rtl/hbb_flags.sv
`timescale 1ns/1ps
module hbb_flags
  import hbb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hbb_ev_t       ev,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] lvl_mid,
  input  logic [LW-1:0] load_n,
  output logic          has_data,
  output logic          is_full
);
  logic some_nx, full_nx;
  logic drain_last, drain_full, fill_first, fill_last;

  // transition events, one wire each
  assign drain_last = ev.pop  && (level   == LW'(1));
  assign drain_full = ev.pop  && (level   == LW'(DEPTH));
  assign fill_first = ev.push && (lvl_mid == '0);
  assign fill_last  = ev.push && (lvl_mid == LW'(DEPTH - 1));

  always_comb begin
    some_nx = has_data;
    full_nx = is_full;
    if (ev.flush) begin
      some_nx = 1'b0;
      full_nx = 1'b0;
    end else if (ev.load) begin
      some_nx = has_data | (load_n != '0);
      full_nx = is_full  | (load_n == LW'(DEPTH));
    end else begin
      if (drain_last) some_nx = 1'b0;
      if (drain_full) full_nx = 1'b0;
      if (fill_first) some_nx = 1'b1;
      if (fill_last)  full_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      has_data <= 1'b0;
      is_full  <= 1'b0;
    end else begin
      has_data <= some_nx;
      is_full  <= full_nx;
    end
  end

  AST_FLUSH_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev.flush |=> (!has_data && !is_full)); // R7

  AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.load && is_full) |=> is_full); // R8

  AST_FILL_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> is_full); // R3

  AST_MID_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.pop && !ev.push && level == LW'(2)) |=> $stable(has_data)); // R6

endmodule

// File: rtl/hbb_store.sv
`timescale 1ns/1ps
module hbb_store
  import hbb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  hbb_ev_t        ev,
  input  logic [LW-1:0]  level,
  input  logic [LW-1:0]  lvl_mid,
  input  logic [LW-1:0]  load_n,
  input  logic [W-1:0]   wr_data,
  input  logic [DEPTH*W-1:0] ld_data,
  output logic [W-1:0]   rd_data
);
  logic [DEPTH*W-1:0] flat;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] q;
    logic [W-1:0] upper;
    logic [W-1:0] host_nx;

    if (i < DEPTH - 1) begin : g_up
      assign upper = flat[(i+1)*W +: W];
    end else begin : g_top
      assign upper = q;
    end

    always_comb begin
      host_nx = ev.pop ? upper : q;
      if (ev.push && lvl_mid == LW'(i)) host_nx = wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || ev.flush)            q <= '0;
      else if (ev.load)                  q <= (load_n > LW'(i)) ? ld_data[i*W +: W] : q;
      else                               q <= host_nx;
    end

    assign flat[i*W +: W] = q;
  end

  assign rd_data = (level == '0) ? '1 : flat[W-1:0];

  AST_HEAD_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.pop && level >= LW'(2)) |=> (flat[W-1:0] == $past(flat[2*W-1:W]))); // R5

  AST_PUSH_INTO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.push && !ev.pop && level == '0) |=> (rd_data == $past(wr_data))); // R3

endmodule

// File: rtl/host_byte_buffer.sv
`timescale 1ns/1ps
module host_byte_buffer
  import hbb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [W-1:0]       wr_data,
  input  logic               rd_en,
  output logic [W-1:0]       rd_data,
  input  logic               ld_en,
  input  logic [DEPTH*W-1:0] ld_data,
  input  logic [LW-1:0]      ld_count,
  input  logic               flush,
  output logic               has_data,
  output logic               is_full
);
  hbb_ev_t       ev;
  logic [LW-1:0] level, lvl_mid, load_n;
  logic          host_quiet;

  assign host_quiet = !flush && !ld_en;

  hbb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .rd_en(rd_en), .wr_en(wr_en), .flush(flush), .ld_en(ld_en),
    .ld_count(ld_count), .level(level),
    .ev(ev), .lvl_mid(lvl_mid), .load_n(load_n));

  hbb_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .ev(ev), .lvl_mid(lvl_mid),
    .load_n(load_n), .level(level));

  hbb_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .ev(ev), .level(level), .lvl_mid(lvl_mid),
    .load_n(load_n), .has_data(has_data), .is_full(is_full));

  hbb_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .ev(ev), .level(level), .lvl_mid(lvl_mid),
    .load_n(load_n), .wr_data(wr_data), .ld_data(ld_data), .rd_data(rd_data));

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_quiet && wr_en && !rd_en && level == LW'(DEPTH))
      |=> (level == LW'(DEPTH) && $stable(rd_data) && $stable(is_full) && $stable(has_data))); // R2

  AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_quiet && rd_en && !wr_en && level == '0)
      |=> (level == '0 && $stable(has_data) && $stable(is_full))); // R4

  AST_RW_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_quiet && rd_en && wr_en && level == LW'(DEPTH))
      |=> (level == LW'(DEPTH) && is_full)); // R9

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0)); // R7

endmodule

// File: tb/test_host_byte_buffer.sv
`timescale 1ns/1ps
module test_host_byte_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, ld_en = 1'b0, flush = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [31:0] ld_data = '0;
  logic [2:0]  ld_count = '0;
  logic [7:0]  rd_data;
  logic        has_data, is_full;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_q [4];
  int         m_n;
  bit         m_s, m_f;

  always #5 clk = ~clk;

  host_byte_buffer i_host_byte_buffer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ld_en(ld_en), .ld_data(ld_data),
    .ld_count(ld_count), .flush(flush), .has_data(has_data), .is_full(is_full));

  function automatic logic [7:0] exp_head();
    return (m_n == 0) ? 8'hFF : m_q[0];
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk(tag, "rd_data", int'(rd_data), int'(exp_head()));
    chk(tag, "has_data", int'(has_data), int'(m_s));
    chk(tag, "is_full", int'(is_full), int'(m_f));
  endtask

  // model: flush, then load, then pop before push
  task automatic model(bit w, logic [7:0] wd, bit r, bit f, bit l,
                       logic [31:0] ldd, logic [2:0] ldc);
    if (f) begin
      foreach (m_q[k]) m_q[k] = 8'h00;
      m_n = 0; m_s = 0; m_f = 0;
    end else if (l) begin
      int c = (ldc > 3'd4) ? 4 : int'(ldc);
      for (int k = 0; k < c; k++) m_q[k] = ldd[8*k +: 8];
      m_n = c;
      if (c >= 1) m_s = 1;
      if (c == 4) m_f = 1;
    end else begin
      if (r && m_n > 0) begin
        if (m_n == 4) m_f = 0;
        if (m_n == 1) m_s = 0;
        for (int k = 0; k < 3; k++) m_q[k] = m_q[k+1];
        m_n--;
      end
      if (w && m_n < 4) begin
        m_q[m_n] = wd;
        m_n++;
        if (m_n == 1) m_s = 1;
        if (m_n == 4) m_f = 1;
      end
    end
  endtask

  task automatic step(string tag, bit w, logic [7:0] wd, bit r, bit f, bit l,
                      logic [31:0] ldd, logic [2:0] ldc);
    @(negedge clk);
    wr_en = w; wr_data = wd; rd_en = r; flush = f;
    ld_en = l; ld_data = ldd; ld_count = ldc;
    #1;
    if (r) chk(tag, "read byte", int'(rd_data), int'(exp_head()));
    @(posedge clk);
    #1 model(w, wd, r, f, l, ldd, ldc);
    @(negedge clk);
    chk_state(tag);
    wr_en = 0; rd_en = 0; flush = 0; ld_en = 0;
  endtask

  task automatic wr(string tag, logic [7:0] d); step(tag, 1, d, 0, 0, 0, '0, '0); endtask
  task automatic rd(string tag);                step(tag, 0, '0, 1, 0, 0, '0, '0); endtask

  initial begin
    #1ms;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    foreach (m_q[k]) m_q[k] = 8'h00;
    m_n = 0; m_s = 0; m_f = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1");

    // R4: empty read
    rd("R4");
    // R3: fill to four
    wr("R3", 8'h11); wr("R3", 8'h22); wr("R3", 8'h33); wr("R3", 8'h44);
    // R2: fifth write dropped
    wr("R2", 8'h55);
    // R9: read and write together at full
    step("R9", 1, 8'h66, 1, 0, 0, '0, '0);
    // R5/R6: drain, order checked
    rd("R6"); rd("R5"); rd("R5"); rd("R6");
    rd("R4");
    // R9 at one entry
    wr("R9", 8'h77);
    step("R9", 1, 8'h88, 1, 0, 0, '0, '0);
    rd("R5");
    // R8: full load, partial load keeps sticky full, zero load keeps has_data
    step("R8", 0, '0, 0, 0, 1, 32'hD4C3B2A1, 3'd4);
    step("R8", 1, 8'h99, 1, 0, 1, 32'h0000F2F1, 3'd2);
    rd("R8"); rd("R8");
    step("R8", 0, '0, 0, 0, 1, 32'hEEEEEEEE, 3'd0);
    step("R8", 0, '0, 0, 0, 1, 32'h04030201, 3'd7);
    // R7: flush beats load and host strobes
    step("R7", 1, 8'hAB, 1, 1, 1, 32'hFFFFFFFF, 3'd4);
    rd("R7");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int p = int'($urandom_range(0, 99));
      step("R5", $urandom_range(0, 1) == 1, 8'($urandom), $urandom_range(0, 1) == 1,
           p < 3, (p >= 3 && p < 9), $urandom, 3'($urandom_range(0, 5)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule